// File: doc/BRIEF.md
# SMT Commit Thread Selector

This block sits in front of the retire stage of a multithreaded out-of-order core. It decides which hardware thread may retire the instruction at the head of its reorder buffer next. For every thread it receives a commit status code, a flag saying the head entry is ready, a flag saying the thread's buffer is empty, and the sequence number of the head entry. From these it forms a qualify mask and, under the selected policy, returns a valid flag and a thread index for each selection lane.

The retire stage may ask for several threads in one cycle, up to its retire width. Each lane is one such request. Lane k sees the rotation order as it stands after lanes 0..k-1 have granted, so one cycle can hand out several round-robin grants in sequence. The policy code is meant to be held steady during operation. Three policies are available. The first is an age-ordered policy that picks the oldest head among the qualified threads. The second is a rotating policy driven by a priority list, in which the thread just granted goes to the back of the list. The third is an aggressive policy that selects exactly as the age-ordered one does. When only one thread is configured, both policies are skipped and the status code alone decides the grant.

Top module: `smt_commit_sel`

## Requirements
- R1: A thread qualifies only when its status code is 0 (idle), 1 (running) or 4 (fetch trap pending), head_rdy is 1 and rob_empty is 0. Codes 2 (squashing) and 3 (trap pending) never qualify.
- R2: Policy codes are 0 aggressive, 1 round-robin, 2 oldest-ready, and 3 is treated as oldest-ready. Aggressive produces the same grants as oldest-ready.
- R3: Under round-robin, a lane grants the first qualifying thread in the priority list. That thread moves to the tail of the list, and the other entries keep their order.
- R4: After reset the priority list is 0,1,..,NUM_THR-1, with thread 0 at the front.
- R5: Under oldest-ready and aggressive, a lane grants the qualifying thread with the smallest head_seq. Ties go to the lower thread index.
- R6: When no thread qualifies, every gnt_vld is 0.
- R7: Lane k sees the priority list after the grants of lanes below k in the same cycle. A lane whose ask bit is 0 shows gnt_vld 0 and leaves the list unchanged.
- R8: Grants under oldest-ready or aggressive leave the round-robin priority list unchanged.
- R9: With NUM_THR = 1, an asking lane is granted thread 0 exactly when its status code is 0, 1 or 4, whatever head_rdy and rob_empty say.
- R10: Sequence numbers are compared as unsigned SEQ_W-bit values, with no wraparound handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Selection policy code (R2) |
| thr_status | input | NUM_THR*3 | Per-thread commit status code, thread t at bits [3t+2:3t] |
| head_rdy | input | NUM_THR | Per-thread head entry ready to retire |
| rob_empty | input | NUM_THR | Per-thread reorder buffer empty |
| head_seq | input | NUM_THR*SEQ_W | Per-thread head sequence number, thread t at slice t |
| ask | input | COMMIT_W | Per-lane selection request |
| gnt_vld | output | COMMIT_W | Per-lane grant valid |
| gnt_thr | output | COMMIT_W*TID_W | Per-lane granted thread index, lane k at slice k |

## Verification
The hardest state to reach from the ports is a rotated priority list in which several lanes grant in the same cycle while only some threads qualify. In that state a later lane must skip both the threads that do not qualify and the thread an earlier lane has just moved to the tail. Long random runs with a sparse ask pattern and biased status codes drive the list through many orders. A small head_seq range makes age ties common. Directed steps cover reset order, an oldest-ready run followed by a switch back to rotation, and head_seq values with the top bit set.

// File: rtl/smt_sel_pkg.sv
`timescale 1ns/1ps
package smt_sel_pkg;
  localparam logic [2:0] ST_IDLE   = 3'd0;
  localparam logic [2:0] ST_RUN    = 3'd1;
  localparam logic [2:0] ST_SQUASH = 3'd2;
  localparam logic [2:0] ST_TRAP   = 3'd3;
  localparam logic [2:0] ST_FTRAP  = 3'd4;

  localparam logic [1:0] POL_AGGR = 2'd0;
  localparam logic [1:0] POL_RR   = 2'd1;
  localparam logic [1:0] POL_OLD  = 2'd2;

  // status codes that allow a thread to retire
  function automatic logic state_allows(input logic [2:0] s);
    return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_FTRAP);
  endfunction

  // rotation is used only for the round-robin code; all others select by age
  function automatic logic uses_rotation(input logic [1:0] p);
    return p == POL_RR;
  endfunction
endpackage

// File: rtl/thr_qualify.sv
`timescale 1ns/1ps
module thr_qualify #(
  parameter int NUM_THR = 4
) (
  input  logic [NUM_THR*3-1:0] thr_status,
  input  logic [NUM_THR-1:0]   head_rdy,
  input  logic [NUM_THR-1:0]   rob_empty,
  output logic [NUM_THR-1:0]   st_ok,
  output logic [NUM_THR-1:0]   qual
);
  import smt_sel_pkg::*;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign st_ok[t] = state_allows(thr_status[t*3 +: 3]);
    assign qual[t]  = st_ok[t] && head_rdy[t] && !rob_empty[t];
  end
endmodule

// File: rtl/oldest_pick.sv
`timescale 1ns/1ps
module oldest_pick #(
  parameter int NUM_THR = 4,
  parameter int SEQ_W   = 16,
  parameter int TID_W   = 2
) (
  input  logic [NUM_THR-1:0]       qual,
  input  logic [NUM_THR*SEQ_W-1:0] head_seq,
  output logic                     found,
  output logic [TID_W-1:0]         tid
);
  logic [SEQ_W-1:0] best_seq;

  // strict less-than keeps the lower index on equal ages
  always_comb begin
    found    = 1'b0;
    tid      = '0;
    best_seq = '0;
    for (int i = 0; i < NUM_THR; i++) begin
      if (qual[i] && (!found || head_seq[i*SEQ_W +: SEQ_W] < best_seq)) begin
        found    = 1'b1;
        tid      = TID_W'(i);
        best_seq = head_seq[i*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/rr_order.sv
`timescale 1ns/1ps
module rr_order #(
  parameter int NUM_THR  = 4,
  parameter int COMMIT_W = 3,
  parameter int TID_W    = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rr_en,
  input  logic [NUM_THR-1:0]               qual,
  input  logic [COMMIT_W-1:0]              ask,
  output logic [COMMIT_W-1:0]              rr_found,
  output logic [COMMIT_W-1:0][TID_W-1:0]   rr_tid
);
  typedef logic [NUM_THR-1:0][TID_W-1:0] list_t;

  list_t                     lst_q;
  list_t [COMMIT_W:0]        stage;
  logic  [COMMIT_W-1:0]      hit_l;
  logic  [COMMIT_W-1:0][TID_W-1:0] pos_l;
  logic  [NUM_THR-1:0]       seen_mask;

  // take entry pos out of the list and append it at the tail
  function automatic list_t move_back(input list_t l, input logic [TID_W-1:0] pos);
    list_t o;
    for (int p = 0; p < NUM_THR - 1; p++)
      o[p] = (p < int'(pos)) ? l[p] : l[p+1];
    o[NUM_THR-1] = l[pos];
    return o;
  endfunction

  always_comb begin
    stage[0] = lst_q;
    for (int k = 0; k < COMMIT_W; k++) begin
      hit_l[k] = 1'b0;
      pos_l[k] = '0;
      for (int p = 0; p < NUM_THR; p++) begin
        if (!hit_l[k] && qual[stage[k][p]]) begin
          hit_l[k] = 1'b1;
          pos_l[k] = TID_W'(p);
        end
      end
      rr_found[k] = ask[k] && hit_l[k];
      rr_tid[k]   = stage[k][pos_l[k]];
      stage[k+1]  = (rr_en && rr_found[k]) ? move_back(stage[k], pos_l[k]) : stage[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_THR; p++) lst_q[p] <= TID_W'(p);
    end else begin
      lst_q <= stage[COMMIT_W];
    end
  end

  always_comb begin
    seen_mask = '0;
    for (int p = 0; p < NUM_THR; p++) seen_mask[lst_q[p]] = 1'b1;
  end

  // R3: the list always holds every thread exactly once
  p_list_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen_mask == {NUM_THR{1'b1}});

  // R3: a lone lane-0 rotating grant lands the thread at the tail
  p_tail_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_en && ask == COMMIT_W'(1) && rr_found[0]) |=> lst_q[NUM_THR-1] == $past(rr_tid[0]));

  // R8: no rotating grant means an unchanged list
  p_list_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_en |=> lst_q == $past(lst_q));
endmodule

// File: rtl/smt_commit_sel.sv
`timescale 1ns/1ps
module smt_commit_sel #(
  parameter int NUM_THR  = 4,
  parameter int SEQ_W    = 16,
  parameter int COMMIT_W = 3,
  localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                policy,
  input  logic [NUM_THR*3-1:0]      thr_status,
  input  logic [NUM_THR-1:0]        head_rdy,
  input  logic [NUM_THR-1:0]        rob_empty,
  input  logic [NUM_THR*SEQ_W-1:0]  head_seq,
  input  logic [COMMIT_W-1:0]       ask,
  output logic [COMMIT_W-1:0]       gnt_vld,
  output logic [COMMIT_W*TID_W-1:0] gnt_thr
);
  import smt_sel_pkg::*;

  logic [NUM_THR-1:0]             st_ok;
  logic [NUM_THR-1:0]             qual;
  logic [COMMIT_W-1:0][TID_W-1:0] gnt_tid;

  thr_qualify #(.NUM_THR(NUM_THR)) u_qual (
    .thr_status(thr_status), .head_rdy(head_rdy), .rob_empty(rob_empty),
    .st_ok(st_ok), .qual(qual)
  );

  for (genvar k = 0; k < COMMIT_W; k++) begin : g_out
    assign gnt_thr[k*TID_W +: TID_W] = gnt_tid[k];
  end

  if (NUM_THR == 1) begin : g_single
    logic unused_single;
    assign unused_single = ^{head_rdy, rob_empty, head_seq, policy, qual};
    for (genvar k = 0; k < COMMIT_W; k++) begin : g_lane
      assign gnt_vld[k] = ask[k] && st_ok[0];
      assign gnt_tid[k] = '0;
      // R9: a lone thread in a squash or trap state is never handed out
      p_single_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld[k] |-> (thr_status[2:0] != ST_SQUASH && thr_status[2:0] != ST_TRAP));
    end
  end else begin : g_multi
    logic                             rr_en;
    logic                             old_found;
    logic [TID_W-1:0]                 old_tid;
    logic [COMMIT_W-1:0]              rr_found;
    logic [COMMIT_W-1:0][TID_W-1:0]   rr_tid;
    logic [SEQ_W-1:0]                 gnt_seq;
    logic                             unused_stok;

    assign unused_stok = ^st_ok;
    assign rr_en       = uses_rotation(policy);

    oldest_pick #(.NUM_THR(NUM_THR), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_old (
      .qual(qual), .head_seq(head_seq), .found(old_found), .tid(old_tid)
    );

    rr_order #(.NUM_THR(NUM_THR), .COMMIT_W(COMMIT_W), .TID_W(TID_W)) u_rr (
      .clk(clk), .rst_n(rst_n), .rr_en(rr_en), .qual(qual), .ask(ask),
      .rr_found(rr_found), .rr_tid(rr_tid)
    );

    assign gnt_seq = head_seq[gnt_tid[0]*SEQ_W +: SEQ_W];

    for (genvar k = 0; k < COMMIT_W; k++) begin : g_lane
      assign gnt_vld[k] = rr_en ? rr_found[k] : (ask[k] && old_found);
      assign gnt_tid[k] = rr_en ? rr_tid[k]   : old_tid;

      // R1: only a qualifying thread is granted
      p_grant_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld[k] |-> qual[gnt_tid[k]]);
      // R7: a lane that is not asked stays silent
      p_quiet_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ask[k] |-> !gnt_vld[k]);
      // R6: nothing qualifies, nothing granted
      p_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (qual == '0) |-> !gnt_vld[k]);
    end

    for (genvar i = 0; i < NUM_THR; i++) begin : g_age
      // R5: no qualifying thread is older than the age-ordered grant
      p_oldest_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_en && gnt_vld[0] && qual[i]) |->
          (head_seq[i*SEQ_W +: SEQ_W] > gnt_seq) ||
          (head_seq[i*SEQ_W +: SEQ_W] == gnt_seq && TID_W'(i) >= gnt_tid[0]));
    end
  end
endmodule

// File: tb/test_smt_commit_sel.sv
`timescale 1ns/1ps
module test_smt_commit_sel;
  localparam int NT = 4;
  localparam int SW = 16;
  localparam int CW = 3;
  localparam int TW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [1:0]    policy;
  logic [2:0]    st [NT];
  logic          rdy [NT];
  logic          emp [NT];
  logic [SW-1:0] seq [NT];
  logic [CW-1:0] ask;
  logic [NT*3-1:0]  st_f;
  logic [NT-1:0]    rdy_f, emp_f;
  logic [NT*SW-1:0] seq_f;
  logic [CW-1:0]    gnt_vld;
  logic [CW*TW-1:0] gnt_thr;

  logic [2:0]    st1;
  logic          rdy1, emp1;
  logic [SW-1:0] seq1;
  logic [CW-1:0] gnt_vld1;
  logic [CW-1:0] gnt_thr1;

  always_comb
    for (int t = 0; t < NT; t++) begin
      st_f[t*3 +: 3]   = st[t];
      rdy_f[t]         = rdy[t];
      emp_f[t]         = emp[t];
      seq_f[t*SW +: SW] = seq[t];
    end

  smt_commit_sel #(.NUM_THR(NT), .SEQ_W(SW), .COMMIT_W(CW)) i_smt_commit_sel (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_status(st_f), .head_rdy(rdy_f),
    .rob_empty(emp_f), .head_seq(seq_f), .ask(ask), .gnt_vld(gnt_vld), .gnt_thr(gnt_thr)
  );

  smt_commit_sel #(.NUM_THR(1), .SEQ_W(SW), .COMMIT_W(CW)) i_smt_commit_sel_one (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_status(st1), .head_rdy(rdy1),
    .rob_empty(emp1), .head_seq(seq1), .ask(ask), .gnt_vld(gnt_vld1), .gnt_thr(gnt_thr1)
  );

  int checks = 0;
  int errors = 0;
  int prio[$];

  function automatic bit ok_state(input logic [2:0] s);
    return s inside {3'd0, 3'd1, 3'd4};
  endfunction

  function automatic bit qualifies(input int t);
    return ok_state(st[t]) && rdy[t] && !emp[t];
  endfunction

  task automatic chk(input string tag, input int lane, input int act_v, input int act_t,
                     input int exp_v, input int exp_t);
    checks++;
    if (act_v != exp_v || (exp_v == 1 && act_t != exp_t)) begin
      errors++;
      $display("FAIL %s lane %0d: got vld=%0d thr=%0d, expected vld=%0d thr=%0d",
               tag, lane, act_v, act_t, exp_v, exp_t);
    end
  endtask

  // evaluate one cycle against the model; inputs are already applied
  task automatic step(input string tag);
    int q[$];
    bit any;
    string tg;
    #1;
    q = prio;
    any = 0;
    for (int t = 0; t < NT; t++) if (qualifies(t)) any = 1;
    for (int k = 0; k < CW; k++) begin
      int ev = 0, et = 0;
      if (ask[k]) begin
        if (policy == 2'd1) begin
          for (int i = 0; i < q.size(); i++)
            if (ev == 0 && qualifies(q[i])) begin
              ev = 1; et = q[i]; q.delete(i); q.push_back(et);
            end
        end else begin
          int best = -1;
          for (int t = 0; t < NT; t++)
            if (qualifies(t) && (best < 0 || seq[t] < seq[best])) best = t;
          if (best >= 0) begin ev = 1; et = best; end
        end
      end
      if (tag != "") tg = tag;
      else if (!ask[k]) tg = "R7";
      else if (!any) tg = "R6";
      else if (policy == 2'd1) tg = (k > 0) ? "R7" : "R3";
      else tg = (policy == 2'd0) ? "R2" : "R5";
      chk(tg, k, int'(gnt_vld[k]), int'(gnt_thr[k*TW +: TW]), ev, et);
      chk("R9", k, int'(gnt_vld1[k]), 0, int'(ask[k] && ok_state(st1)), 0);
    end
    prio = q;
    if (!rst_n) begin
      prio = {};
      for (int t = 0; t < NT; t++) prio.push_back(t);
    end
    @(negedge clk);
  endtask

  task automatic set_all(input logic [2:0] s, input logic r, input logic e);
    for (int t = 0; t < NT; t++) begin st[t] = s; rdy[t] = r; emp[t] = e; seq[t] = SW'(t); end
  endtask

  task automatic randomize_inputs(input int seq_range);
    for (int t = 0; t < NT; t++) begin
      st[t]  = 3'($urandom_range(0, 4));
      rdy[t] = ($urandom_range(0, 3) != 0);
      emp[t] = ($urandom_range(0, 5) == 0);
      seq[t] = SW'($urandom_range(0, seq_range));
    end
    st1  = 3'($urandom_range(0, 4));
    rdy1 = 1'($urandom);
    emp1 = 1'($urandom);
    seq1 = SW'($urandom);
    ask  = CW'($urandom);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step("R4");
    step("R4");
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) prio.push_back(t);
    rst_n = 1'b0; policy = 2'd1; ask = '1;
    set_all(3'd1, 1'b1, 1'b0);
    st1 = 3'd1; rdy1 = 1'b1; emp1 = 1'b0; seq1 = '0;
    @(negedge clk);
    do_reset();

    // R4: ascending order after reset, lanes chain (R7)
    step("R4");
    step("R3");

    // R6: nobody qualifies
    set_all(3'd2, 1'b1, 1'b0);
    step("R6");
    set_all(3'd3, 1'b1, 1'b0);
    step("R1");
    set_all(3'd4, 1'b1, 1'b1);
    step("R1");

    // R5: all the same age picks thread 0
    policy = 2'd2;
    set_all(3'd0, 1'b1, 1'b0);
    for (int t = 0; t < NT; t++) seq[t] = 16'd7;
    step("R5");
    // R10: top-bit values compared unsigned
    seq[0] = 16'hFFFF; seq[1] = 16'h8001; seq[2] = 16'h8000; seq[3] = 16'h7FFF;
    step("R10");
    st[3] = 3'd3;
    step("R10");
    // R2: aggressive and code 3 select like oldest-ready
    policy = 2'd0; step("R2");
    policy = 2'd3; step("R2");

    // R8: age-ordered grants leave the rotation order alone
    do_reset();
    policy = 2'd2; set_all(3'd1, 1'b1, 1'b0); ask = '1;
    for (int i = 0; i < 5; i++) step("R8");
    policy = 2'd1;
    step("R8");

    // R9: single thread ignores ready and empty
    st1 = 3'd4; rdy1 = 1'b0; emp1 = 1'b1;
    step("R9");
    st1 = 3'd2; rdy1 = 1'b1; emp1 = 1'b0;
    step("R9");

    // random runs under each policy
    policy = 2'd1;
    for (int i = 0; i < 600; i++) begin randomize_inputs(7); step(""); end
    policy = 2'd2;
    for (int i = 0; i < 300; i++) begin randomize_inputs(3); step(""); end
    policy = 2'd0;
    for (int i = 0; i < 200; i++) begin randomize_inputs(65535); step(""); end
    policy = 2'd1;
    for (int i = 0; i < 400; i++) begin randomize_inputs(7); step(""); end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule